// File: doc/BRIEF.md
# Framebuffer Display Scan Controller

This block scans a fixed true-colour raster (640x480 visible) out of a linear framebuffer kept in external memory. A timing generator walks an 800x525-clock frame at one pixel per clock. For every visible position, the block issues one 32-bit word read to memory. It then places the returned red, green and blue bytes on the pixel outputs, in step with a delayed copy of the data-enable and sync flags.

Software controls the block through two word registers. Index 0 is the framebuffer base; only its top 11 bits are kept, so a framebuffer starts on a 2 MiB boundary. Index 1 is the control word, which holds an enable bit and a 180-degree rotate bit. Each display row spans 1024 words of memory, and only the first 640 of them are fetched. The memory side has a single request strobe and a data-return strobe. It has no back-pressure: the memory must take every request and return its word a fixed `RD_LAT` cycles later. The controller therefore issues each address ahead of its display slot, so the data lands on the visible pixel.

A base or rotate change written mid-frame waits for the frame boundary, so one frame never mixes two settings. The enable bit acts at once.

Top module: `fbscan_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, no read is requested and the pixel outputs, data enable and syncs are all 0. Both registers read 0. The first raster position after reset is column 0, row 0.
- R2: Writing index 0 (`reg_idx`=0) stores bits 31:21 of the data. Reading index 0 returns those bits with bits 20:0 as zero, starting in the cycle after the write.
- R3: Index 1 stores bit 0 (enable) and bit 1 (rotate). Reading index 1 returns these two bits, with bits 31:2 reading 0 whatever was written.
- R4: A line lasts H_ACTIVE+H_FRONT+H_SYNC+H_BACK clocks, and a frame lasts V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines. `pix_de` is high for column < H_ACTIVE and row < V_ACTIVE. `pix_hsync` (active high) is high for column in [H_ACTIVE+H_FRONT, H_ACTIVE+H_FRONT+H_SYNC). `pix_vsync` (active high) is high for row in [V_ACTIVE+V_FRONT, V_ACTIVE+V_FRONT+V_SYNC). All three appear RD_LAT+2 cycles after the raster position.
- R5: When enabled and not rotated, a visible position (x, y) raises `rd_req` for one cycle, one cycle after the position. `rd_addr` is the byte address base + 4*(y*1024 + x). Positions outside the visible area issue no request.
- R6: With rotate set, the position (x, y) fetches word (H_ACTIVE-1-x, V_ACTIVE-1-y). The last pixel of the last row is therefore fetched first.
- R7: The word returned for a position drives `pix_r`=bits 23:16, `pix_g`=bits 15:8 and `pix_b`=bits 7:0, RD_LAT+2 cycles after the position. Bits 31:24 of the word have no effect on any output.
- R8: While enable is 0, no requests are issued and the pixel colour outputs are 0 from the next cycle on. Enable and disable take effect in the cycle after the write, with no wait for a frame boundary.
- R9: A new base or rotate value is used for fetches only from the frame that follows the next frame boundary, which is the clock edge that ends the last position of a frame. A write made in the same cycle as that edge is used by the frame that starts there.
- R10: Memory returns `rd_valid` with `rd_data` exactly RD_LAT cycles after the cycle in which `rd_req` was high. There is no stall, so every request is accepted in the cycle it is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 1 | Register index: 0 base, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by reg_idx |
| rd_req | output | 1 | Memory word read request |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_valid | input | 1 | Returned word valid (RD_LAT after request) |
| rd_data | input | 32 | Returned pixel word |
| pix_de | output | 1 | Visible-area data enable |
| pix_hsync | output | 1 | Horizontal sync, active high |
| pix_vsync | output | 1 | Vertical sync, active high |
| pix_r | output | 8 | Red level |
| pix_g | output | 8 | Green level |
| pix_b | output | 8 | Blue level |

## Verification
A base register write and the frame-boundary load of the active base can fall in the same cycle. The bench waits until its own raster count reaches the last position of a frame and writes a new base in exactly that cycle. It then writes a second base in the very next cycle. The request address of every visible fetch is compared against a model, which must show the first value over the whole next frame and the second value only from the frame after that. Enable toggles are also placed mid-frame, so the immediate blanking of colour and requests is judged against the same cycle-exact model.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

  localparam int unsigned WORD_W = 32;

  // register indices on the control port
  localparam logic REG_IDX_BASE = 1'b0;
  localparam logic REG_IDX_CTRL = 1'b1;

  // control word bit positions
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_ROT_BIT = 1;

  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } scan_flags_t;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

endpackage

// File: rtl/fbscan_regs.sv
module fbscan_regs
  import fbscan_pkg::*;
#(
  parameter int unsigned BASE_KEEP = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              idx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              frame_end,
  output logic [WORD_W-1:0] rdata,
  output logic              en,
  output logic              rot_act,
  output logic [WORD_W-1:0] base_act
);

  localparam int unsigned LOW_W = WORD_W - BASE_KEEP;

  logic [BASE_KEEP-1:0] base_pend;
  logic [BASE_KEEP-1:0] base_live;
  logic [BASE_KEEP-1:0] base_next;
  logic                 rot_pend;
  logic                 rot_next;
  logic                 en_q;
  logic                 rot_q;
  logic                 wr_base;
  logic                 wr_ctrl;
  logic                 unused_wbits;

  assign wr_base = we && (idx == REG_IDX_BASE);
  assign wr_ctrl = we && (idx == REG_IDX_CTRL);

  // a write landing on the frame-boundary edge is forwarded into the load
  assign base_next = wr_base ? wdata[WORD_W-1 -: BASE_KEEP] : base_pend;
  assign rot_next  = wr_ctrl ? wdata[CTRL_ROT_BIT] : rot_pend;

  assign unused_wbits = ^wdata[LOW_W-1:CTRL_ROT_BIT+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_pend <= '0;
      rot_pend  <= 1'b0;
      en_q      <= 1'b0;
    end else begin
      if (wr_base) base_pend <= wdata[WORD_W-1 -: BASE_KEEP];
      if (wr_ctrl) begin
        rot_pend <= wdata[CTRL_ROT_BIT];
        en_q     <= wdata[CTRL_EN_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_live <= '0;
      rot_q     <= 1'b0;
    end else if (frame_end) begin
      base_live <= base_next;
      rot_q     <= rot_next;
    end
  end

  always_comb begin
    rdata = '0;
    if (idx == REG_IDX_BASE) begin
      rdata = {base_pend, {LOW_W{1'b0}}};
    end else begin
      rdata[CTRL_EN_BIT]  = en_q;
      rdata[CTRL_ROT_BIT] = rot_pend;
    end
  end

  assign en       = en_q;
  assign rot_act  = rot_q;
  assign base_act = {base_live, {LOW_W{1'b0}}};

  AST_BASE_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(base_live)); // R9

  AST_ROT_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(rot_q)); // R9

endmodule

// File: rtl/fbscan_timing.sv
module fbscan_timing #(
  parameter int unsigned H_ACTIVE = 640,
  parameter int unsigned H_FRONT  = 16,
  parameter int unsigned H_SYNC   = 96,
  parameter int unsigned H_BACK   = 48,
  parameter int unsigned V_ACTIVE = 480,
  parameter int unsigned V_FRONT  = 10,
  parameter int unsigned V_SYNC   = 2,
  parameter int unsigned V_BACK   = 33,
  parameter int unsigned HW       = 10,
  parameter int unsigned VW       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] col,
  output logic [VW-1:0] row,
  output logic          active,
  output logic          hsync,
  output logic          vsync,
  output logic          frame_end
);

  localparam int unsigned H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int unsigned V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS    = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_VIS    = VW'(V_ACTIVE);
  localparam logic [HW-1:0] HS_FIRST = HW'(H_ACTIVE + H_FRONT);
  localparam logic [HW-1:0] HS_LAST  = HW'(H_ACTIVE + H_FRONT + H_SYNC - 1);
  localparam logic [VW-1:0] VS_FIRST = VW'(V_ACTIVE + V_FRONT);
  localparam logic [VW-1:0] VS_LAST  = VW'(V_ACTIVE + V_FRONT + V_SYNC - 1);

  logic line_end;

  assign line_end  = (col == H_LAST);
  assign frame_end = line_end && (row == V_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (line_end) begin
      col <= '0;
      row <= (row == V_LAST) ? '0 : row + 1'b1;
    end else begin
      col <= col + 1'b1;
    end
  end

  assign active = (col < H_VIS) && (row < V_VIS);
  assign hsync  = (col >= HS_FIRST) && (col <= HS_LAST);
  assign vsync  = (row >= VS_FIRST) && (row <= VS_LAST);

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (col == H_LAST) |=> (col == '0)); // R4

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (col == '0 && row == '0)); // R4

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (col != H_LAST) |=> $stable(row)); // R4

endmodule

// File: rtl/fbscan_addr.sv
module fbscan_addr
  import fbscan_pkg::*;
#(
  parameter int unsigned H_ACTIVE    = 640,
  parameter int unsigned V_ACTIVE    = 480,
  parameter int unsigned STRIDE_LOG2 = 10,
  parameter int unsigned HW          = 10,
  parameter int unsigned VW          = 10
) (
  input  logic [HW-1:0]     col,
  input  logic [VW-1:0]     row,
  input  logic              rot,
  input  logic [WORD_W-1:0] base,
  output logic [WORD_W-1:0] addr
);

  localparam logic [HW-1:0] X_MAX = HW'(H_ACTIVE - 1);
  localparam logic [VW-1:0] Y_MAX = VW'(V_ACTIVE - 1);

  logic [HW-1:0]     x;
  logic [VW-1:0]     y;
  logic [WORD_W-1:0] word_off;

  // rotation mirrors both axes inside the visible rectangle
  assign x = rot ? (X_MAX - col) : col;
  assign y = rot ? (Y_MAX - row) : row;

  assign word_off = (WORD_W'(y) << STRIDE_LOG2) + WORD_W'(x);
  assign addr     = base + (word_off << 2);

endmodule

// File: rtl/fbscan_pipe.sv
module fbscan_pipe
  import fbscan_pkg::*;
#(
  parameter int unsigned RD_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_want,
  input  logic [WORD_W-1:0] fetch_addr,
  input  scan_flags_t       flags_in,
  input  logic              en,
  output logic              rd_req,
  output logic [WORD_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output scan_flags_t       flags_out,
  output rgb_t              pix
);

  scan_flags_t stage0;
  scan_flags_t dly [RD_LAT];
  scan_flags_t aligned;
  logic        unused_top;

  assign unused_top = ^rd_data[WORD_W-1:24];

  // request stage: one cycle after the raster position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
      stage0  <= '0;
    end else begin
      rd_req <= fetch_want;
      if (fetch_want) rd_addr <= fetch_addr;
      stage0 <= flags_in;
    end
  end

  // flag delay matching the memory latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(RD_LAT); i++) dly[i] <= '0;
    end else begin
      dly[0] <= stage0;
      for (int i = 1; i < int'(RD_LAT); i++) dly[i] <= dly[i-1];
    end
  end

  assign aligned = dly[RD_LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_out <= '0;
      pix       <= '0;
    end else begin
      flags_out <= aligned;
      pix       <= (en && rd_valid && aligned.de) ? rgb_t'(rd_data[23:0]) : '0;
    end
  end

  AST_BLACK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pix == '0)); // R8

  AST_RETURN_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> aligned.de); // R10

  AST_REQ_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[1:0] == 2'b00)); // R5

endmodule

// File: rtl/fbscan_ctrl.sv
module fbscan_ctrl
  import fbscan_pkg::*;
#(
  parameter int unsigned H_ACTIVE    = 640,
  parameter int unsigned H_FRONT     = 16,
  parameter int unsigned H_SYNC      = 96,
  parameter int unsigned H_BACK      = 48,
  parameter int unsigned V_ACTIVE    = 480,
  parameter int unsigned V_FRONT     = 10,
  parameter int unsigned V_SYNC      = 2,
  parameter int unsigned V_BACK      = 33,
  parameter int unsigned STRIDE_LOG2 = 10,
  parameter int unsigned BASE_KEEP   = 11,
  parameter int unsigned RD_LAT      = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_valid,
  input  logic [31:0] rd_data,
  output logic        pix_de,
  output logic        pix_hsync,
  output logic        pix_vsync,
  output logic [7:0]  pix_r,
  output logic [7:0]  pix_g,
  output logic [7:0]  pix_b
);

  localparam int unsigned H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int unsigned V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int unsigned HW      = $clog2(H_TOTAL);
  localparam int unsigned VW      = $clog2(V_TOTAL);

  logic [HW-1:0]     col;
  logic [VW-1:0]     row;
  logic              active;
  logic              hsync;
  logic              vsync;
  logic              frame_end;
  logic              ctrl_en;
  logic              rot_act;
  logic [WORD_W-1:0] base_act;
  logic [WORD_W-1:0] fetch_addr;
  scan_flags_t       flags_now;
  scan_flags_t       flags_out;
  rgb_t              pix;

  fbscan_regs #(
    .BASE_KEEP(BASE_KEEP)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .idx      (reg_idx),
    .wdata    (reg_wdata),
    .frame_end(frame_end),
    .rdata    (reg_rdata),
    .en       (ctrl_en),
    .rot_act  (rot_act),
    .base_act (base_act)
  );

  fbscan_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
    .HW(HW), .VW(VW)
  ) u_timing (
    .clk      (clk),
    .rst_n    (rst_n),
    .col      (col),
    .row      (row),
    .active   (active),
    .hsync    (hsync),
    .vsync    (vsync),
    .frame_end(frame_end)
  );

  fbscan_addr #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .STRIDE_LOG2(STRIDE_LOG2),
    .HW(HW), .VW(VW)
  ) u_addr (
    .col (col),
    .row (row),
    .rot (rot_act),
    .base(base_act),
    .addr(fetch_addr)
  );

  assign flags_now = '{de: active, hs: hsync, vs: vsync};

  fbscan_pipe #(
    .RD_LAT(RD_LAT)
  ) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_want(active && ctrl_en),
    .fetch_addr(fetch_addr),
    .flags_in  (flags_now),
    .en        (ctrl_en),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .flags_out (flags_out),
    .pix       (pix)
  );

  assign pix_de    = flags_out.de;
  assign pix_hsync = flags_out.hs;
  assign pix_vsync = flags_out.vs;
  assign pix_r     = pix.r;
  assign pix_g     = pix.g;
  assign pix_b     = pix.b;

  AST_NO_FETCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !rd_req); // R8

  AST_REQ_IN_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !rd_req); // R5

endmodule

// File: tb/tb_fbscan_ctrl.sv
`timescale 1ns/1ps
module tb_fbscan_ctrl;

  localparam int HA = 6, HF = 1, HS = 2, HB = 1;
  localparam int VA = 4, VF = 1, VS = 1, VB = 1;
  localparam int LAT = 3;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FR = HT * VT;
  localparam int D  = LAT + 2;
  localparam logic [31:0] MASK = 32'hFFE0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_idx = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        pix_de, pix_hsync, pix_vsync;
  logic [7:0]  pix_r, pix_g, pix_b;

  int total = 0;
  int fails = 0;
  bit run_chk = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fbscan_ctrl #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .STRIDE_LOG2(10), .BASE_KEEP(11), .RD_LAT(LAT)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .pix_de(pix_de), .pix_hsync(pix_hsync), .pix_vsync(pix_vsync),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ {a[9:2], 24'h5A_C3_96};
  endfunction

  // memory model: fixed latency LAT
  logic        mq_v [LAT];
  logic [31:0] mq_a [LAT];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin mq_v[i] <= 1'b0; mq_a[i] <= '0; end
    end else begin
      mq_v[0] <= rd_req;
      mq_a[0] <= rd_addr;
      for (int i = 1; i < LAT; i++) begin mq_v[i] <= mq_v[i-1]; mq_a[i] <= mq_a[i-1]; end
    end
  end
  assign rd_valid = mq_v[LAT-1];
  assign rd_data  = memf(mq_a[LAT-1]);

  // reference model of the requirements
  int          fpos;
  logic [31:0] mpend, mbase;
  logic        mrotp, mrota, men, out_gate;
  logic        e_req [D];
  logic [31:0] e_addr [D];
  logic        e_de [D];
  logic        e_hs [D];
  logic        e_vs [D];
  int          hh, vv, xx, yy;
  logic        cde;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpos <= 0; mpend <= '0; mbase <= '0; mrotp <= 1'b0; mrota <= 1'b0;
      men <= 1'b0; out_gate <= 1'b0;
      for (int i = 0; i < D; i++) begin
        e_req[i] <= 1'b0; e_addr[i] <= '0; e_de[i] <= 1'b0; e_hs[i] <= 1'b0; e_vs[i] <= 1'b0;
      end
    end else begin
      hh  = fpos % HT;
      vv  = fpos / HT;
      cde = (hh < HA) && (vv < VA);
      xx  = mrota ? (HA - 1 - hh) : hh;
      yy  = mrota ? (VA - 1 - vv) : vv;
      e_req[0]  <= cde && men;
      e_addr[0] <= mbase + 32'((yy * 1024 + xx) * 4);
      e_de[0]   <= cde;
      e_hs[0]   <= (hh >= HA + HF) && (hh < HA + HF + HS);
      e_vs[0]   <= (vv >= VA + VF) && (vv < VA + VF + VS);
      for (int i = 1; i < D; i++) begin
        e_req[i] <= e_req[i-1]; e_addr[i] <= e_addr[i-1];
        e_de[i] <= e_de[i-1]; e_hs[i] <= e_hs[i-1]; e_vs[i] <= e_vs[i-1];
      end
      out_gate <= men;
      fpos <= (fpos == FR - 1) ? 0 : fpos + 1;
      if (reg_we && !reg_idx) mpend <= reg_wdata & MASK;
      if (reg_we && reg_idx) begin men <= reg_wdata[0]; mrotp <= reg_wdata[1]; end
      if (fpos == FR - 1) begin
        mbase <= (reg_we && !reg_idx) ? (reg_wdata & MASK) : mpend;
        mrota <= (reg_we && reg_idx) ? reg_wdata[1] : mrotp;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [23:0] exp_rgb;
  always @(negedge clk) begin
    if (rst_n && run_chk && !done) begin
      chk((rd_req == e_req[0]) && (!e_req[0] || rd_addr == e_addr[0]),
          "R5 R6 R8 R9 request", {31'd0, rd_req, rd_addr}, {31'd0, e_req[0], e_addr[0]});
      chk({pix_de, pix_hsync, pix_vsync} == {e_de[D-1], e_hs[D-1], e_vs[D-1]},
          "R4 timing", {61'd0, pix_de, pix_hsync, pix_vsync},
          {61'd0, e_de[D-1], e_hs[D-1], e_vs[D-1]});
      exp_rgb = (e_req[D-1] && out_gate) ? memf(e_addr[D-1]) : 32'd0;
      chk({pix_r, pix_g, pix_b} == exp_rgb, "R7 R8 R10 pixel",
          {40'd0, pix_r, pix_g, pix_b}, {40'd0, exp_rgb});
    end
  end

  task automatic wr(input logic idx, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rdchk(input logic idx, input logic [31:0] exp, input string tag);
    reg_idx = idx;
    #0.5;
    chk(reg_rdata == exp, tag, {32'd0, reg_rdata}, {32'd0, exp});
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!rd_req && !pix_de && !pix_hsync && !pix_vsync, "R1 reset flags",
        {60'd0, rd_req, pix_de, pix_hsync, pix_vsync}, 64'd0);
    chk({pix_r, pix_g, pix_b} == 24'd0, "R1 reset colour", {40'd0, pix_r, pix_g, pix_b}, 64'd0);
    rdchk(1'b0, 32'd0, "R1 base reset");
    rdchk(1'b1, 32'd0, "R1 ctrl reset");
    @(negedge clk);
    rst_n = 1'b1;
    #0.5 run_chk = 1'b1;

    repeat (FR) @(negedge clk);          // disabled frame: black, no fetch (R8)
    wr(1'b0, 32'h1234_5678);
    rdchk(1'b0, 32'h1234_5678 & MASK, "R2 base readback");
    wr(1'b1, 32'h0000_0001);
    rdchk(1'b1, 32'h1, "R3 ctrl readback");
    repeat (2 * FR) @(negedge clk);

    wr(1'b1, 32'h0000_0003);             // R6 rotate
    rdchk(1'b1, 32'h3, "R3 ctrl rotate readback");
    repeat (2 * FR + 5) @(negedge clk);

    // R9: write on the boundary cycle, then one cycle after it
    do @(negedge clk); while (fpos != FR - 1);
    reg_we = 1'b1; reg_idx = 1'b0; reg_wdata = 32'h4000_0000;
    @(negedge clk);
    reg_wdata = 32'h8765_4321;
    @(negedge clk);
    reg_we = 1'b0;
    rdchk(1'b0, 32'h8765_4321 & MASK, "R2 R9 base readback");
    repeat (2 * FR) @(negedge clk);

    wr(1'b1, 32'hFFFF_FFFD);             // R3 upper bits ignored
    rdchk(1'b1, 32'h1, "R3 upper bits read zero");
    repeat (FR + 7) @(negedge clk);

    wr(1'b1, 32'h0000_0000);             // R8 immediate disable
    rdchk(1'b1, 32'h0, "R8 ctrl off readback");
    repeat (FR) @(negedge clk);
    wr(1'b1, 32'h0000_0002);             // rotate with enable clear stays dark
    rdchk(1'b1, 32'h2, "R3 R8 rotate only");
    repeat (FR) @(negedge clk);
    wr(1'b1, 32'h0000_0001);             // re-enable mid-frame
    repeat (FR + 13) @(negedge clk);
    finish_run();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

endmodule